// File: doc/BRIEF.md
# Size-Scaled Transfer Timeout Watchdog

This block supervises a single data transfer and settles it as completed, failed or timed out. A transfer begins with a one-cycle start request that carries the byte count. On that request the block derives a deadline in milliseconds from the byte count, then watches two status inputs. One is a level-sensitive transfer-complete flag. The other is a DMA error flag. Time is measured in pulses of a millisecond tick input, which is generated elsewhere.

The deadline depends on the transfer size. The byte count is rounded up to whole mebibytes, and 333 ms is allowed per mebibyte, with a floor of 1000 ms. Elapsed time is the difference between a free-running tick counter and its value at the start, so the measurement stays correct when the counter wraps.

Each transfer ends with a one-cycle report. The report carries an outcome code and a cleanup pulse that tells the surrounding logic to drop its DMA enable controls. When the outcome is success, the report also carries a write-one-to-clear pulse for the completion status bit. The block then returns to idle.

Top module: `xfer_watchdog`

## Requirements
- R1: The deadline in milliseconds is 333 times the byte count divided by 2^20, rounded up. For example, 3 MiB + 1 byte gives 1332 and 5 MiB gives 1665.
- R2: A computed deadline below 1000 ms is replaced by 1000 ms. Byte counts of 0, 4096 and exactly 3 MiB all get a deadline of 1000.
- R3: `dmaErr` is sampled in the cycle after the start cycle. If it is high there, the block skips waiting and reports outcome code 2 (I/O error). It does this even when `xferDone` is also high.
- R4: While waiting, a high `xferDone` ends the transfer with outcome code 1 (success). `doneClr` pulses in the same cycle as `outValid`.
- R5: While waiting, the transfer ends with outcome code 3 (timeout) once the ticks counted since the start cycle exceed the deadline. The tick at the start edge counts as the first tick.
- R6: Elapsed time is measured relative to the tick count at start. A deadline that spans a wrap of the tick counter expires after the same number of ticks as one that does not.
- R7: If completion is seen in the same cycle that the deadline is exceeded, the outcome is success.
- R8: Every outcome is reported by a single-cycle `outValid` together with a `dmaCleanup` pulse. `busy` is low in the cycle after the report, and `doneClr` pulses only with success.
- R9: A `dmaErr` that rises after waiting has begun has no effect on the outcome or on when it is reported.
- R10: A `startReq` while `busy` is high is ignored. The running transfer keeps its deadline and start time.
- R11: After reset, `busy`, `outValid`, `doneClr` and `dmaCleanup` are low, and `outCode` is 0 (no outcome).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse per elapsed millisecond |
| startReq | input | 1 | Starts supervision of a transfer when idle |
| byteCount | input | BYTE_W | Total bytes of the transfer, sampled with startReq |
| xferDone | input | 1 | Transfer-complete status level |
| dmaErr | input | 1 | DMA error status level |
| busy | output | 1 | A transfer is under supervision |
| outValid | output | 1 | One-cycle outcome report |
| outCode | output | 2 | Last outcome: 0 none, 1 success, 2 I/O error, 3 timeout |
| doneClr | output | 1 | Write-one pulse clearing the completion status bit |
| dmaCleanup | output | 1 | Pulse telling the host logic to clear its DMA enables |

## Verification
Number the start edge as edge 1, with the tick held high every cycle and a deadline of DL. Under that numbering, an I/O error report is visible after edge 2. Completion that is already present is reported after edge 3. Completion that first appears after edge n (n of 2 or more) is reported after edge n+1, and a timeout is reported after edge DL+2. The bench drives every input just after a falling edge and samples every output at the following falling edge. It counts edges from the start edge until `outValid` appears and compares that count with the figure the rules above predict. The wrap case is placed so that the tick counter rolls over partway through the deadline.

// File: rtl/xwd_pkg.sv
package xwd_pkg;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_OK      = 2'd1,
    OUT_IOERR   = 2'd2,
    OUT_TIMEOUT = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CHECK,
    S_WAIT,
    S_REPORT
  } wdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch deadline and start tick
    logic watching;  // expiry compare is meaningful
  } dpCtrl_t;

endpackage

// File: rtl/xwd_deadline.sv
module xwd_deadline #(
  parameter int BYTE_W     = 32,
  parameter int MIB_SHIFT  = 20,
  parameter int MS_PER_MIB = 333,
  parameter int FLOOR_MS   = 1000,
  parameter int DL_W       = 22
) (
  input  logic [BYTE_W-1:0] byteCount,
  output logic [DL_W-1:0]   deadline
);

  localparam int MIB_W = BYTE_W - MIB_SHIFT + 1;

  logic [MIB_W-1:0] wholeMib;
  logic             partialMib;
  logic [MIB_W-1:0] sizeMib;
  logic [DL_W-1:0]  scaledMs;

  always_comb begin
    wholeMib   = MIB_W'(byteCount >> MIB_SHIFT);
    partialMib = |byteCount[MIB_SHIFT-1:0];
    sizeMib    = wholeMib + MIB_W'(partialMib);
    scaledMs   = DL_W'(sizeMib) * DL_W'(MS_PER_MIB);
    if (scaledMs < DL_W'(FLOOR_MS)) deadline = DL_W'(FLOOR_MS);
    else                            deadline = scaledMs;
  end

endmodule

// File: rtl/xwd_datapath.sv
module xwd_datapath
  import xwd_pkg::*;
#(
  parameter int BYTE_W     = 32,
  parameter int TICK_W     = 24,
  parameter int MIB_SHIFT  = 20,
  parameter int MS_PER_MIB = 333,
  parameter int FLOOR_MS   = 1000,
  parameter int DL_W       = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic [BYTE_W-1:0] byteCount,
  input  dpCtrl_t           ctrl,
  output logic              expired
);

  localparam int CMP_W = ((DL_W > TICK_W) ? DL_W : TICK_W) + 1;

  logic [DL_W-1:0]   nextDeadline;
  logic [DL_W-1:0]   dlReg;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] startTick;
  logic [TICK_W-1:0] elapsed;

  xwd_deadline #(
    .BYTE_W(BYTE_W), .MIB_SHIFT(MIB_SHIFT), .MS_PER_MIB(MS_PER_MIB),
    .FLOOR_MS(FLOOR_MS), .DL_W(DL_W)
  ) u_deadline (
    .byteCount(byteCount),
    .deadline (nextDeadline)
  );

  // free-running millisecond counter, allowed to wrap
  always_ff @(posedge clk) begin
    if (!rstN)       tickCnt <= '0;
    else if (msTick) tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlReg     <= DL_W'(FLOOR_MS);
      startTick <= '0;
    end else if (ctrl.capture) begin
      dlReg     <= nextDeadline;
      startTick <= tickCnt;
    end
  end

  // modular difference stays right across a wrap
  assign elapsed = tickCnt - startTick;
  assign expired = ctrl.watching &&
                   (CMP_W'(elapsed) > CMP_W'(dlReg));

  assert_deadline_floor_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (dlReg >= DL_W'(FLOOR_MS)));

  assert_expiry_needs_time_R5: assert property (@(posedge clk) disable iff (!rstN)
    expired |-> (elapsed != '0));

endmodule

// File: rtl/xwd_control.sv
module xwd_control
  import xwd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     xferDone,
  input  logic     dmaErr,
  input  logic     expired,
  output dpCtrl_t  ctrl,
  output logic     busy,
  output logic     outValid,
  output outcome_e outCode,
  output logic     doneClr,
  output logic     dmaCleanup
);

  wdState_e state;
  wdState_e stateNext;
  outcome_e codeNext;

  always_comb begin
    stateNext = state;
    codeNext  = outCode;
    unique case (state)
      S_IDLE:   if (startReq) stateNext = S_CHECK;
      S_CHECK: begin
        if (dmaErr) begin
          codeNext  = OUT_IOERR;
          stateNext = S_REPORT;
        end else begin
          stateNext = S_WAIT;
        end
      end
      S_WAIT: begin
        // completion is checked first so it wins a tie with expiry
        if (xferDone) begin
          codeNext  = OUT_OK;
          stateNext = S_REPORT;
        end else if (expired) begin
          codeNext  = OUT_TIMEOUT;
          stateNext = S_REPORT;
        end
      end
      S_REPORT: stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      outCode <= OUT_NONE;
    end else begin
      state   <= stateNext;
      outCode <= codeNext;
    end
  end

  always_comb begin
    ctrl.capture  = (state == S_IDLE) && startReq;
    ctrl.watching = (state == S_WAIT);
  end

  assign busy       = (state != S_IDLE);
  assign outValid   = (state == S_REPORT);
  assign dmaCleanup = (state == S_REPORT);
  assign doneClr    = (state == S_REPORT) && (outCode == OUT_OK);

  assert_ioerr_early_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && dmaErr) |=> (outValid && outCode == OUT_IOERR));

  assert_clear_only_ok_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneClr |-> (outValid && outCode == OUT_OK));

  assert_timeout_after_expiry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == OUT_TIMEOUT) |-> $past(expired));

  assert_done_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && xferDone && expired) |=> (outCode == OUT_OK));

  assert_single_report_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> (!outValid && !busy));

  assert_wait_ignores_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == OUT_IOERR) |-> $past(state == S_CHECK));

endmodule

// File: rtl/xfer_watchdog.sv
module xfer_watchdog
  import xwd_pkg::*;
#(
  parameter int BYTE_W     = 32,
  parameter int TICK_W     = 24,
  parameter int MIB_SHIFT  = 20,
  parameter int MS_PER_MIB = 333,
  parameter int FLOOR_MS   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              startReq,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic              xferDone,
  input  logic              dmaErr,
  output logic              busy,
  output logic              outValid,
  output logic [1:0]        outCode,
  output logic              doneClr,
  output logic              dmaCleanup
);

  localparam int MIB_W   = BYTE_W - MIB_SHIFT + 1;
  localparam int SCALE_W = MIB_W + $clog2(MS_PER_MIB + 1);
  localparam int FLOOR_W = $clog2(FLOOR_MS + 1);
  localparam int DL_W    = (SCALE_W > FLOOR_W) ? SCALE_W : FLOOR_W;

  dpCtrl_t  dpCtrl;
  logic     expired;
  outcome_e codeEnum;

  xwd_datapath #(
    .BYTE_W(BYTE_W), .TICK_W(TICK_W), .MIB_SHIFT(MIB_SHIFT),
    .MS_PER_MIB(MS_PER_MIB), .FLOOR_MS(FLOOR_MS), .DL_W(DL_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .msTick   (msTick),
    .byteCount(byteCount),
    .ctrl     (dpCtrl),
    .expired  (expired)
  );

  xwd_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .xferDone  (xferDone),
    .dmaErr    (dmaErr),
    .expired   (expired),
    .ctrl      (dpCtrl),
    .busy      (busy),
    .outValid  (outValid),
    .outCode   (codeEnum),
    .doneClr   (doneClr),
    .dmaCleanup(dmaCleanup)
  );

  assign outCode = codeEnum;

  assert_cleanup_with_report_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> dmaCleanup);

endmodule

// File: tb/xfer_watchdog_tb.sv
module xfer_watchdog_tb;

  localparam int NEVER = 99999;
  localparam int NV    = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msTick = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] byteCount = '0;
  logic        xferDone = 1'b0;
  logic        dmaErr = 1'b0;
  logic        busy, outValid, doneClr, dmaCleanup;
  logic [1:0]  outCode;

  int total = 0;
  int bad = 0;
  int tbTicks = 0;

  always #2 clk = ~clk;

  xfer_watchdog #(.TICK_W(12)) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .startReq(startReq),
    .byteCount(byteCount), .xferDone(xferDone), .dmaErr(dmaErr),
    .busy(busy), .outValid(outValid), .outCode(outCode),
    .doneClr(doneClr), .dmaCleanup(dmaCleanup)
  );

  always @(posedge clk) if (rstN && msTick) tbTicks <= tbTicks + 1;

  // columns: bytes, err edge, done edge, expected code, expected latency
  localparam int vBytes [NV] = '{0, 3145728, 3145729, 5242880, 12582912,
                                 4096, 4096, 4096, 4096, 4096, 4096,
                                 3145729, 0, 0};
  localparam int vErr   [NV] = '{NEVER, NEVER, NEVER, NEVER, NEVER,
                                 0, 1, 0, NEVER, NEVER, NEVER,
                                 5, NEVER, NEVER};
  localparam int vDone  [NV] = '{NEVER, NEVER, NEVER, NEVER, NEVER,
                                 NEVER, NEVER, 0, 0, 1, 40,
                                 1200, 1001, 1002};
  localparam int vCode  [NV] = '{3, 3, 3, 3, 3, 2, 2, 2, 1, 1, 1, 1, 1, 3};
  localparam int vLat   [NV] = '{1002, 1002, 1334, 1667, 3998, 2, 2, 2,
                                 3, 3, 41, 1201, 1002, 1002};
  localparam string vReq [NV] = '{"R2", "R2", "R1", "R1", "R1", "R3", "R3",
                                  "R3", "R4", "R4", "R4", "R9", "R7", "R5"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one transfer; edges counted from the start edge (edge 1)
  task automatic runXfer(input int bytes, input int errE, input int doneE,
                         input int restartE, output int lat, output int code,
                         output int clr, output int cln);
    int n = 0;
    lat = -1; code = -1; clr = -1; cln = -1;
    byteCount = bytes;
    if (errE == 0) dmaErr = 1'b1;
    if (doneE == 0) xferDone = 1'b1;
    startReq = 1'b1;
    while (n < 6000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      startReq = 1'b0;
      byteCount = 32'd0;
      if (outValid) begin
        lat = n; code = outCode; clr = doneClr; cln = dmaCleanup;
        break;
      end
      if (n == errE) dmaErr = 1'b1;
      if (n == doneE) xferDone = 1'b1;
      if (n == restartE) begin
        startReq = 1'b1;
        byteCount = 32'd12582912;
      end
    end
    xferDone = 1'b0;
    dmaErr = 1'b0;
  endtask

  initial begin
    int lat, code, clr, cln;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy == 0 && outValid == 0 && doneClr == 0 && dmaCleanup == 0, "R11", busy, 0);
    check(outCode == 0, "R11", outCode, 0);
    rstN = 1'b1;
    msTick = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runXfer(vBytes[i], vErr[i], vDone[i], NEVER, lat, code, clr, cln);
      check(lat == vLat[i], vReq[i], lat, vLat[i]);
      check(code == vCode[i], vReq[i], code, vCode[i]);
      check(clr == (vCode[i] == 1 ? 1 : 0), "R4", clr, vCode[i] == 1 ? 1 : 0);
      check(cln == 1, "R8", cln, 1);
      @(negedge clk);
      check(busy == 0 && outValid == 0, "R8", busy, 0);
    end

    // R10: start while busy keeps the running deadline
    runXfer(4096, NEVER, NEVER, 50, lat, code, clr, cln);
    check(lat == 1002, "R10", lat, 1002);
    check(code == 3, "R10", code, 3);
    @(negedge clk);
    check(busy == 0, "R10", busy, 0);

    // R6: start so the 12-bit tick counter wraps mid-deadline
    while ((tbTicks % 4096) != 3900) @(negedge clk);
    runXfer(0, NEVER, NEVER, NEVER, lat, code, clr, cln);
    check(lat == 1002, "R6", lat, 1002);
    check(code == 3, "R6", code, 3);

    // R8/R11: outCode holds, no stray report while idle
    repeat (5) @(negedge clk);
    check(outValid == 0 && dmaCleanup == 0 && busy == 0, "R8", outValid, 0);
    check(outCode == 3, "R8", outCode, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule